// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block holds the cycle-level control, address sequencing and storage of a flow-through synchronous burst memory. On every rising clock edge it samples two active-low address strobes, three chip selects, an advance strobe and a set of per-lane write enables. From these it decides whether to load a new start address, step through a four-beat burst, hold, or drop into a deselected power-down state. The host strobe can only start reads and can be overridden by the primary select. The controller strobe can start reads or writes.

Storage is organised as four byte lanes of nine bits each: eight data bits and one parity bit that the caller supplies and the block stores as plain data. Read data is flow-through. The word at the registered address appears on the data output during the clock period that follows the edge that registered it. A static ordering input picks a counting or an XOR burst sequence. Writes touch only the lanes whose enables are active.

Top module: `sburst_sram`

## Requirements
- R1: While `rst_n` is low and after its release, with no strobe asserted, `rd_oe` is 0 and `rdata` is 0.
- R2: A low `astb_host_n` sampled with `sel_n` low, `sel_hi` high and `sel_lo_n` low registers `addr_in` and performs a read. This happens whatever the lane write enables and `astb_ctl_n` are doing. In the following period `rd_oe` is 1 and `rdata` holds the stored word at that address.
- R3: `astb_host_n` has no effect while `sel_n` is high. With `astb_ctl_n` and `adv_n` also high, the outputs stay unchanged.
- R4: A low `astb_host_n` sampled with `sel_n` low but `sel_hi` low or `sel_lo_n` high puts the block into power-down, so `rd_oe` goes to 0.
- R5: A low `astb_ctl_n` without a qualifying host strobe, and with all three selects active, registers `addr_in`. The access is a write if any lane enable is active and a read otherwise. If a secondary select is inactive, the block powers down instead.
- R6: A low `astb_ctl_n` sampled with `sel_n` high puts the block into power-down.
- R7: With `mode_ilv` = 0, beat k of a burst uses low address bits (start + k) mod 4. The upper address bits stay fixed.
- R8: With `mode_ilv` = 1, beat k of a burst uses low address bits start XOR k. The upper address bits stay fixed.
- R9: With both strobes high, a low `adv_n` advances an active burst by one beat and keeps its read or write type. A high `adv_n` holds the address. While powered down, `adv_n` has no effect.
- R10: Lane i occupies `wdata`/`rdata` bits [9i+8:9i], with bit 9i+8 as its parity. Lane i is written only when `lane_wr_n[i]` or `all_wr_n` is low. Other lanes keep their data and parity.
- R11: During write bursts and power-down, `rd_oe` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| mode_ilv | input | 1 | Burst order: 0 counting, 1 XOR; static while running |
| addr_in | input | ADDR_W | External word address |
| astb_host_n | input | 1 | Host address strobe, active low, read only |
| astb_ctl_n | input | 1 | Controller address strobe, active low, read or write |
| sel_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Secondary chip select, active high |
| sel_lo_n | input | 1 | Tertiary chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| wdata | input | LANES*LANE_W | Write data, lane i at bits [9i+8:9i] |
| rdata | output | LANES*LANE_W | Flow-through read data, 0 when disabled |
| rd_oe | output | 1 | Read data enable |

## Verification
A wrong strobe decode or select qualification shows up within one period as a wrong `rd_oe` level. A stale burst type is exposed the same way. A burst-address or beat-counter fault shows as wrong `rdata` on the first advance, because the model pre-fills every word with distinct contents. A lane-merge fault stays hidden until the word is read back, so the bench reads partially written words directly and through random bursts.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Decoded action for one clock edge
  typedef enum logic [2:0] {
    OP_HOLD    = 3'd0,
    OP_LOAD_RD = 3'd1,
    OP_LOAD_WR = 3'd2,
    OP_STEP    = 3'd3,
    OP_PWRDN   = 3'd4
  } sbs_op_e;

endpackage

// File: rtl/sbs_strobe_dec.sv
module sbs_strobe_dec
  import sbs_pkg::*;
(
  input  logic    astb_host_n,
  input  logic    astb_ctl_n,
  input  logic    sel_n,
  input  logic    sel_hi,
  input  logic    sel_lo_n,
  input  logic    adv_n,
  input  logic    any_wr,
  output sbs_op_e op
);

  logic sec_ok;
  logic host_hit;

  assign sec_ok   = sel_hi & ~sel_lo_n;
  // host strobe counts only when the primary select is active
  assign host_hit = ~astb_host_n & ~sel_n;

  always_comb begin
    op = OP_HOLD;
    if (host_hit) begin
      op = sec_ok ? OP_LOAD_RD : OP_PWRDN;
    end else if (!astb_ctl_n) begin
      if (sel_n || !sec_ok) begin
        op = OP_PWRDN;
      end else begin
        op = any_wr ? OP_LOAD_WR : OP_LOAD_RD;
      end
    end else if (!adv_n) begin
      op = OP_STEP;
    end
  end

endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ilv,
  input  sbs_op_e           op,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              active,
  output logic              is_wr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_go
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [BEAT_W-1:0] start_q, start_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              upd_en;

  function automatic logic [BEAT_W-1:0] order_lo(
    input logic              ilv,
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat
  );
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

  // next-state process
  always_comb begin
    act_d   = act_q;
    wr_d    = wr_q;
    hi_d    = hi_q;
    start_d = start_q;
    beat_d  = beat_q;
    unique case (op)
      OP_LOAD_RD, OP_LOAD_WR: begin
        act_d   = 1'b1;
        wr_d    = (op == OP_LOAD_WR);
        hi_d    = addr_in[ADDR_W-1:BEAT_W];
        start_d = addr_in[BEAT_W-1:0];
        beat_d  = '0;
      end
      OP_STEP: begin
        if (act_q) beat_d = beat_q + 1'b1;
      end
      OP_PWRDN: begin
        act_d = 1'b0;
        wr_d  = 1'b0;
      end
      default: ;
    endcase
  end

  assign upd_en = (op != OP_HOLD);

  // register process with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (upd_en) begin
      act_q   <= act_d;
      wr_q    <= wr_d;
      hi_q    <= hi_d;
      start_q <= start_d;
      beat_q  <= beat_d;
    end
  end

  assign active  = act_q;
  assign is_wr   = wr_q;
  assign rd_addr = {hi_q, order_lo(mode_ilv, start_q, beat_q)};
  // a write lands on the address that becomes current at this edge
  assign wr_addr = {hi_d, order_lo(mode_ilv, start_d, beat_d)};
  assign wr_go   = (op == OP_LOAD_WR) | ((op == OP_STEP) & act_q & wr_q);

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_go,
  input  logic [LANES-1:0]        lane_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic              lane_we;

    assign lane_we = wr_go & lane_en[g];

    always_ff @(posedge clk) begin
      if (lane_we) store[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = store[rd_addr];
  end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int BEAT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_ilv,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    astb_host_n,
  input  logic                    astb_ctl_n,
  input  logic                    sel_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    adv_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    all_wr_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rd_oe
);

  localparam int WORD_W = LANES * LANE_W;

  sbs_op_e           op;
  logic [LANES-1:0]  lane_en;
  logic              any_wr;
  logic              active;
  logic              is_wr;
  logic              wr_go;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] rd_word;

  assign lane_en = ~lane_wr_n | {LANES{~all_wr_n}};
  assign any_wr  = |lane_en;

  sbs_strobe_dec u_dec (
    .astb_host_n (astb_host_n),
    .astb_ctl_n  (astb_ctl_n),
    .sel_n       (sel_n),
    .sel_hi      (sel_hi),
    .sel_lo_n    (sel_lo_n),
    .adv_n       (adv_n),
    .any_wr      (any_wr),
    .op          (op)
  );

  sbs_burst_addr #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_ilv (mode_ilv),
    .op       (op),
    .addr_in  (addr_in),
    .active   (active),
    .is_wr    (is_wr),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr),
    .wr_go    (wr_go)
  );

  sbs_lane_array #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_mem (
    .clk     (clk),
    .wr_go   (wr_go),
    .lane_en (lane_en),
    .wr_addr (wr_addr),
    .wdata   (wdata),
    .rd_addr (rd_addr),
    .rd_word (rd_word)
  );

  assign rd_oe = active & ~is_wr;
  assign rdata = rd_oe ? rd_word : '0;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int LANES  = 4,
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              astb_host_n,
  input logic              astb_ctl_n,
  input logic              sel_n,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic              adv_n,
  input logic [LANES-1:0]  lane_wr_n,
  input logic              all_wr_n,
  input logic [WORD_W-1:0] rdata,
  input logic              rd_oe
);

  a_r2_host_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!astb_host_n && !sel_n && sel_hi && !sel_lo_n) |=> rd_oe);

  a_r3_host_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!astb_host_n && sel_n && astb_ctl_n && adv_n) |=> ($stable(rd_oe) && $stable(rdata)));

  a_r4_host_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
    (!astb_host_n && !sel_n && (!sel_hi || sel_lo_n)) |=> !rd_oe);

  a_r6_ctl_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
    (!astb_ctl_n && sel_n) |=> !rd_oe);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (astb_host_n && astb_ctl_n && adv_n) |=> ($stable(rd_oe) && $stable(rdata)));

  a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (astb_host_n && !astb_ctl_n && !sel_n && sel_hi && !sel_lo_n
     && (!all_wr_n || (lane_wr_n != {LANES{1'b1}}))) |=> !rd_oe);

endmodule

bind sburst_sram sbs_checker #(
  .LANES  (LANES),
  .WORD_W (LANES * LANE_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .astb_host_n (astb_host_n),
  .astb_ctl_n  (astb_ctl_n),
  .sel_n       (sel_n),
  .sel_hi      (sel_hi),
  .sel_lo_n    (sel_lo_n),
  .adv_n       (adv_n),
  .lane_wr_n   (lane_wr_n),
  .all_wr_n    (all_wr_n),
  .rdata       (rdata),
  .rd_oe       (rd_oe)
);

// File: tb/test_sburst_sram.sv
module test_sburst_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          mode_ilv;
  logic [AW-1:0] addr_in;
  logic          astb_host_n, astb_ctl_n;
  logic          sel_n, sel_hi, sel_lo_n;
  logic          adv_n;
  logic [NL-1:0] lane_wr_n;
  logic          all_wr_n;
  logic [WW-1:0] wdata;
  logic [WW-1:0] rdata;
  logic          rd_oe;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [WW-1:0] mm [DEPTH];
  logic          m_act, m_wr;
  logic [AW-1:0] m_start;
  logic [1:0]    m_beat;
  string         m_tag;

  sburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .BEAT_W(2)) i_sburst_sram (
    .clk(clk), .rst_n(rst_n), .mode_ilv(mode_ilv), .addr_in(addr_in),
    .astb_host_n(astb_host_n), .astb_ctl_n(astb_ctl_n), .sel_n(sel_n),
    .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .adv_n(adv_n),
    .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n), .wdata(wdata),
    .rdata(rdata), .rd_oe(rd_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = mode_ilv ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
    return {m_start[AW-1:2], lo};
  endfunction

  function automatic logic [WW-1:0] lane_mask(input logic [NL-1:0] en);
    logic [WW-1:0] m;
    m = '0;
    for (int i = 0; i < NL; i++) if (en[i]) m[i*LW +: LW] = '1;
    return m;
  endfunction

  task automatic m_write();
    logic [WW-1:0] msk;
    msk = lane_mask(~lane_wr_n | {NL{~all_wr_n}});
    mm[m_addr()] = (mm[m_addr()] & ~msk) | (wdata & msk);
  endtask

  // model update for one rising edge, from the requirements
  task automatic model_edge();
    logic sec;
    logic wr_any;
    sec    = sel_hi && !sel_lo_n;
    wr_any = (lane_wr_n != '1) || !all_wr_n;
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_tag = "R1";
    end else if (!astb_host_n && !sel_n) begin
      if (sec) begin m_act = 1; m_wr = 0; m_start = addr_in; m_beat = 0; m_tag = "R2"; end
      else begin m_act = 0; m_wr = 0; m_tag = "R4"; end
    end else if (!astb_ctl_n) begin
      if (sel_n) begin m_act = 0; m_wr = 0; m_tag = "R6"; end
      else if (!sec) begin m_act = 0; m_wr = 0; m_tag = "R5"; end
      else begin
        m_act = 1; m_wr = wr_any; m_start = addr_in; m_beat = 0; m_tag = "R5";
        if (wr_any) m_write();
      end
    end else if (!adv_n) begin
      m_tag = mode_ilv ? "R8" : "R7";
      if (m_act) begin
        m_beat = m_beat + 2'd1;
        if (m_wr) m_write();
      end else m_tag = "R9";
    end else begin
      m_tag = astb_host_n ? "R9" : "R3";
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    astb_host_n = 1; astb_ctl_n = 1; adv_n = 1;
    sel_n = 0; sel_hi = 1; sel_lo_n = 0;
    lane_wr_n = '1; all_wr_n = 1;
  endtask

  // one clock: model at the edge, compare at the following falling edge
  task automatic tick();
    logic          e_oe;
    logic [WW-1:0] e_d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    e_oe = m_act && !m_wr;
    e_d  = e_oe ? mm[m_addr()] : '0;
    check(rd_oe == e_oe, (m_act && m_wr) ? "R11" : m_tag, {35'd0, rd_oe}, {35'd0, e_oe});
    check(rdata == e_d, (m_act && m_wr) ? "R11" : m_tag, rdata, e_d);
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle();
    tick();
    tick();
    rst_n = 1;
    tick();
    check(rd_oe == 0 && rdata == '0, "R1", rdata, '0);
  endtask

  task automatic rand_cycle();
    astb_host_n = ($urandom % 100) >= 12;
    astb_ctl_n  = ($urandom % 100) >= 18;
    sel_n       = ($urandom % 100) >= 85;
    sel_hi      = ($urandom % 100) < 92;
    sel_lo_n    = ($urandom % 100) >= 92;
    adv_n       = ($urandom % 100) >= 60;
    lane_wr_n   = ($urandom % 2) ? 4'hF : 4'($urandom);
    all_wr_n    = ($urandom % 100) >= 10;
    addr_in     = AW'($urandom);
    wdata       = {4'($urandom), $urandom};
    tick();
  endtask

  // directed burst with explicitly computed beat addresses
  task automatic burst_dir(input logic [AW-1:0] a0, input bit ilv);
    logic [AW-1:0] ea;
    logic [1:0]    lo;
    idle();
    astb_ctl_n = 0; addr_in = a0;
    tick();
    for (int k = 0; k < 5; k++) begin
      lo = ilv ? (a0[1:0] ^ 2'(k)) : (a0[1:0] + 2'(k));
      ea = {a0[AW-1:2], lo};
      check(rd_oe && rdata == mm[ea], ilv ? "R8" : "R7", rdata, mm[ea]);
      idle();
      adv_n = 0;
      tick();
    end
    idle();
  endtask

  initial begin
    logic [WW-1:0] old_w;
    logic [WW-1:0] new_w;
    logic [WW-1:0] held;
    void'($urandom(32'd4242));
    mode_ilv = 0; addr_in = '0; wdata = '0;
    m_start = '0; m_beat = '0; m_act = 0; m_wr = 0; m_tag = "R1";
    @(negedge clk);
    do_reset();

    // pre-fill every word through single controller-strobe writes
    for (int a = 0; a < DEPTH; a++) begin
      idle();
      astb_ctl_n = 0; all_wr_n = 0; addr_in = AW'(a);
      wdata = {4'(a), 32'(a * 32'h01030507 + 32'h9e3779b9)};
      tick();
    end
    idle();
    tick();

    burst_dir(6'h15, 1'b0);   // R7 linear from low bits 1

    // R2: both strobes low with lane writes requested is a read
    idle();
    astb_host_n = 0; astb_ctl_n = 0; lane_wr_n = '0; addr_in = 6'h30; wdata = '1;
    old_w = mm[6'h30];
    tick();
    check(rd_oe && rdata == old_w, "R2", rdata, old_w);

    // R3: host strobe while primary select high is ignored
    held = rdata;
    idle();
    astb_host_n = 0; sel_n = 1; addr_in = 6'h01;
    tick();
    check(rd_oe && rdata == held, "R3", rdata, held);

    // R10: write only lanes 0 and 2, then read back
    idle();
    old_w = mm[6'h22];
    new_w = 36'h5A5A5A5A5;
    astb_ctl_n = 0; lane_wr_n = 4'b1010; addr_in = 6'h22; wdata = new_w;
    tick();
    check(rd_oe == 0, "R11", {35'd0, rd_oe}, '0);
    idle();
    astb_host_n = 0; addr_in = 6'h22;
    tick();
    check(rdata == ((old_w & ~36'h007FC01FF) | (new_w & 36'h007FC01FF)), "R10",
          rdata, (old_w & ~36'h007FC01FF) | (new_w & 36'h007FC01FF));

    // R4: host strobe with secondary select off
    idle();
    astb_host_n = 0; sel_hi = 0;
    tick();
    check(rd_oe == 0 && rdata == '0, "R4", rdata, '0);

    // R9: advance while powered down changes nothing
    idle();
    adv_n = 0;
    tick();
    check(rd_oe == 0, "R9", {35'd0, rd_oe}, '0);

    // R6: controller strobe with primary select high
    idle();
    astb_host_n = 0; addr_in = 6'h05;
    tick();
    idle();
    astb_ctl_n = 0; sel_n = 1;
    tick();
    check(rd_oe == 0, "R6", {35'd0, rd_oe}, '0);

    idle();
    for (int n = 0; n < 1500; n++) rand_cycle();

    // second phase: XOR ordering, mode changed only under reset
    idle();
    mode_ilv = 1;
    do_reset();
    burst_dir(6'h29, 1'b1);   // R8 from low bits 1: 1,0,3,2
    for (int n = 0; n < 1500; n++) rand_cycle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule